// File: doc/BRIEF.md
# Edge-aligned PWM counter core

This block produces a single pulse-width-modulated waveform from three 16-bit setup values: a start count, a terminal count and a mid-point threshold. An up-counter walks from the start count toward the terminal count and then restarts. The waveform is high for the stretch of each period in which the count has reached the mid-point. The period therefore equals the terminal count minus the start count, and the high time equals the terminal count minus the mid-point. Every completed period raises a one-cycle overflow pulse. The pulse sets a sticky flag that software clears with a write-one strobe, and the flag, gated by an interrupt enable, forms the interrupt request.

The setup values arrive as plain inputs from a register block outside this core. The core copies them into shadow registers only at a period boundary, or while it is not counting, so a change never cuts a period short. A small state machine controls the counter. Idle is entered whenever the enable is low. Run means the counter is stepping through a valid period. Halt means the enable is high but the terminal count is not above the start count. The transitions are as follows. Idle goes to Run, or to Halt, when the enable is seen high, depending on whether the live setup is valid. Run stays in Run, or falls to Halt, at each period boundary, again depending on the new setup. Halt goes to Run as soon as the setup becomes valid. Run and Halt both return to Idle when the enable drops.

Top module: `pwm_core`

## Requirements
- R1: While running, the internal count takes the values start, start+1, … up to terminal−1, then reloads start, so one period lasts terminal−start cycles.
- R2: `ovf_pulse` is high for exactly the cycle in which the count holds terminal−1, and is low in every other cycle.
- R3: `pwm_out` is high in the cycles where the count is greater than or equal to the mid-point (unsigned), giving terminal−mid high cycles per period.
- R4: A mid-point at or below the start count keeps `pwm_out` high for the whole period, and a mid-point at or above the terminal count keeps it low.
- R5: If the terminal count is less than or equal to the start count, `pwm_out` stays low and no overflow pulse occurs.
- R6: While `en` is low, `pwm_out` and `ovf_pulse` are low. The first clock edge that samples `en` high loads the start count, and the waveform for count=start appears in the cycle after that edge.
- R7: Changes to the start, terminal and mid-point inputs are taken into use only at the edge that ends a period, or at any edge while not running.
- R8: An overflow pulse sets `tof_flag` at the next edge, and the flag stays set until it is cleared.
- R9: `tof_clr` high at an edge clears `tof_flag`, even if an overflow pulse is present in the same cycle.
- R10: `irq` is high exactly when `irq_en` is high and `tof_flag` is set.
- R11: Under reset (`rst_n` low), `pwm_out`, `ovf_pulse`, `tof_flag` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Starts (1) or stops (0) waveform generation |
| irq_en | input | 1 | Interrupt enable |
| init_val | input | 16 | Start count |
| term_val | input | 16 | Terminal count |
| mid_val | input | 16 | Mid-point threshold |
| tof_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| pwm_out | output | 1 | PWM waveform |
| ovf_pulse | output | 1 | One-cycle period-complete pulse |
| tof_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The waveform and the overflow pulse come straight from the state and count registers. When `en` is driven high between two edges, the first expected value appears just after the next edge and a new value follows one cycle later for each step. The bench therefore queues one expected pair per cycle, starting at that edge, and pops them one cycle apart, sampling shortly after each rising edge. The flag changes one edge after the overflow or clear that causes it, while `irq` follows `irq_en` with no delay. Inputs change on falling edges, so every check falls between the edge that produced its value and the next one. A mid-point change lands in the middle of a period, and the queue keeps the old threshold until the next boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // enable low, count parked at start value
        ST_RUN  = 2'd1,  // stepping through a valid period
        ST_HALT = 2'd2   // enabled but terminal <= start
    } pwm_state_e;

    localparam int unsigned CFG_FIELDS = 3;
    localparam int unsigned FLD_INIT   = 0;
    localparam int unsigned FLD_TERM   = 1;
    localparam int unsigned FLD_MID    = 2;

endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init_in,
    input  logic [W-1:0] term_in,
    input  logic [W-1:0] mid_in,
    output logic [W-1:0] init_q,
    output logic [W-1:0] term_q,
    output logic [W-1:0] mid_q
);

    logic [CFG_FIELDS-1:0][W-1:0] live;
    logic [CFG_FIELDS-1:0][W-1:0] held;

    assign live[FLD_INIT] = init_in;
    assign live[FLD_TERM] = term_in;
    assign live[FLD_MID]  = mid_in;

    // One shadow register per setup field
    for (genvar g = 0; g < CFG_FIELDS; g++) begin : g_fld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[g] <= '0;
            end else if (load) begin
                held[g] <= live[g];
            end
        end
    end

    assign init_q = held[FLD_INIT];
    assign term_q = held[FLD_TERM];
    assign mid_q  = held[FLD_MID];

    // R7: without a load strobe the shadow copy must not move
    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));

endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
    import pwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] init_in,
    input  logic [W-1:0] term_in,
    input  logic [W-1:0] init_s,
    input  logic [W-1:0] term_s,
    input  logic [W-1:0] mid_s,
    output logic         load,
    output logic         pwm,
    output logic         ovf
);

    localparam logic [W-1:0] ONE = W'(1);

    pwm_state_e   state_q, state_d;
    logic [W-1:0] cnt_q;
    logic         last_step;
    logic         live_ok;

    assign live_ok   = term_in > init_in;
    assign last_step = (state_q == ST_RUN) && (cnt_q == term_s - ONE);
    assign load      = !en || (state_q != ST_RUN) || last_step;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = live_ok ? ST_RUN : ST_HALT;
            ST_RUN: begin
                if (!en)            state_d = ST_IDLE;
                else if (last_step) state_d = live_ok ? ST_RUN : ST_HALT;
            end
            ST_HALT: begin
                if (!en) state_d = ST_IDLE;
                else     state_d = live_ok ? ST_RUN : ST_HALT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= init_in;
        else           cnt_q <= cnt_q + ONE;
    end

    // Outputs (Moore)
    always_comb begin
        pwm = 1'b0;
        ovf = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                pwm = cnt_q >= mid_s;
                ovf = last_step;
            end
            ST_IDLE, ST_HALT: begin
                pwm = 1'b0;
                ovf = 1'b0;
            end
            default: begin
                pwm = 1'b0;
                ovf = 1'b0;
            end
        endcase
    end

    // R1: count stays inside [start, terminal) while running
    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q >= init_s && cnt_q < term_s));

    // R1: after the period-end cycle the count restarts at the start value
    assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (state_q != ST_RUN || cnt_q == init_s));

    // R5: Halt only with a non-increasing setup
    assert_halt_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (term_s <= init_s));

endmodule

// File: rtl/pwm_flag.sv
module pwm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic clr,
    input  logic ie,
    output logic tof,
    output logic irq
);

    // Sticky overflow flag, clear has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   tof <= 1'b0;
        else if (clr) tof <= 1'b0;
        else if (ovf) tof <= 1'b1;
    end

    assign irq = ie & tof;

    assert_tof_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> tof);

    assert_tof_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tof && !clr) |=> tof);

    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tof);

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         irq_en,
    input  logic [W-1:0] init_val,
    input  logic [W-1:0] term_val,
    input  logic [W-1:0] mid_val,
    input  logic         tof_clr,
    output logic         pwm_out,
    output logic         ovf_pulse,
    output logic         tof_flag,
    output logic         irq
);

    logic         load;
    logic [W-1:0] init_s, term_s, mid_s;

    pwm_shadow #(.W(W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .init_in (init_val),
        .term_in (term_val),
        .mid_in  (mid_val),
        .init_q  (init_s),
        .term_q  (term_s),
        .mid_q   (mid_s)
    );

    pwm_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .init_in (init_val),
        .term_in (term_val),
        .init_s  (init_s),
        .term_s  (term_s),
        .mid_s   (mid_s),
        .load    (load),
        .pwm     (pwm_out),
        .ovf     (ovf_pulse)
    );

    pwm_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf   (ovf_pulse),
        .clr   (tof_clr),
        .ie    (irq_en),
        .tof   (tof_flag),
        .irq   (irq)
    );

    // R6: a low enable silences the waveform and the overflow pulse next cycle
    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_out && !ovf_pulse));

    // R5: a non-increasing live setup seen at a load never yields an overflow next cycle
    assert_no_ovf_bad_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && term_val <= init_val) |=> !ovf_pulse);

endmodule

// File: tb/test_pwm_core.sv
module test_pwm_core;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         irq_en = 1'b0;
    logic [W-1:0] init_val = '0;
    logic [W-1:0] term_val = '0;
    logic [W-1:0] mid_val = '0;
    logic         tof_clr = 1'b0;
    logic         pwm_out, ovf_pulse, tof_flag, irq;

    always #2 clk = ~clk;  // 250 MHz

    pwm_core #(.W(W)) i_pwm_core (
        .clk(clk), .rst_n(rst_n), .en(en), .irq_en(irq_en),
        .init_val(init_val), .term_val(term_val), .mid_val(mid_val),
        .tof_clr(tof_clr), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse),
        .tof_flag(tof_flag), .irq(irq)
    );

    typedef struct {
        logic  pwm;
        logic  ovf;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Monitor: one expected item per cycle, sampled 1 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "pwm_out", 32'(pwm_out), 32'(e.pwm));
                check(e.req == "R5" ? "R5" : "R2", "ovf_pulse", 32'(ovf_pulse), 32'(e.ovf));
            end
        end
    end

    // Driver: program a setup, enable, queue expected cycles; optional mid-point change
    task automatic run_pwm(input int ini, input int trm, input int mid, input int ncyc,
                           input int chg_at, input int mid_new, input string req);
        int p;
        wait (exp_q.size() == 0);
        @(negedge clk);
        init_val = W'(ini);
        term_val = W'(trm);
        mid_val  = W'(mid);
        en       = 1'b1;
        p = trm - ini;
        for (int k = 0; k < ncyc; k++) begin
            exp_t e;
            e.req = req;
            if (p <= 0) begin
                e.pwm = 1'b0;
                e.ovf = 1'b0;
            end else begin
                int c, start, m;
                c     = ini + (k % p);
                start = k - (k % p);
                m     = (chg_at >= 0 && start >= chg_at) ? mid_new : mid;
                e.pwm = (c >= m);
                e.ovf = (c == trm - 1);
            end
            exp_q.push_back(e);
        end
        if (chg_at >= 0) begin
            repeat (chg_at) @(negedge clk);
            mid_val = W'(mid_new);
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "pwm_out", 32'(pwm_out), 0);
        check("R11", "ovf_pulse", 32'(ovf_pulse), 0);
        check("R11", "tof_flag", 32'(tof_flag), 0);
        check("R11", "irq", 32'(irq), 0);
        rst_n = 1'b1;

        // R6: disabled output stays quiet with a setup that would otherwise drive high
        init_val = 16'd0; term_val = 16'd5; mid_val = 16'd0;
        repeat (4) @(negedge clk);
        check("R6", "pwm_out idle", 32'(pwm_out), 0);
        check("R6", "ovf_pulse idle", 32'(ovf_pulse), 0);

        // R1 R3: period 10, high 5
        run_pwm(10, 20, 15, 30, -1, 0, "R3");
        @(posedge clk); #1;
        // R8: overflow occurred, flag sticky
        check("R8", "tof_flag after run", 32'(tof_flag), 1);
        // R10: irq gated by enable
        check("R10", "irq ie=0", 32'(irq), 0);
        @(negedge clk); irq_en = 1'b1; #1;
        check("R10", "irq ie=1", 32'(irq), 1);
        @(negedge clk); tof_clr = 1'b1;
        @(negedge clk); tof_clr = 1'b0;
        check("R9", "tof_flag cleared", 32'(tof_flag), 0);
        check("R10", "irq after clear", 32'(irq), 0);

        // R4: mid at/below start -> always high; then R6 disable mid-run drops output
        run_pwm(0, 8, 0, 20, -1, 0, "R4");
        @(posedge clk); #1;
        check("R6", "pwm_out after disable", 32'(pwm_out), 0);
        // R4: mid at/above terminal -> always low
        run_pwm(5, 9, 9, 12, -1, 0, "R4");
        run_pwm(5, 9, 200, 8, -1, 0, "R4");
        // R5: terminal <= start
        run_pwm(7, 7, 0, 12, -1, 0, "R5");
        run_pwm(9, 3, 0, 8, -1, 0, "R5");
        // R1: period of one cycle, overflow every cycle
        run_pwm(3, 4, 3, 6, -1, 0, "R1");
        // R7: mid-point change mid-period takes effect at the next boundary
        run_pwm(10, 20, 15, 40, 14, 12, "R7");
        // R1 R3 at large counts near the top of the range
        run_pwm(65530, 65535, 65532, 12, -1, 0, "R3");

        // R9: clear held while overflowing every cycle keeps the flag low
        wait (exp_q.size() == 0);
        @(negedge clk);
        init_val = 16'd3; term_val = 16'd4; mid_val = 16'd0;
        en = 1'b1; tof_clr = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "tof_flag with clear and overflow", 32'(tof_flag), 0);
        check("R2", "ovf_pulse every cycle", 32'(ovf_pulse), 1);
        tof_clr = 1'b0;
        @(negedge clk);
        check("R8", "tof_flag set after clear released", 32'(tof_flag), 1);
        check("R10", "irq set", 32'(irq), 1);
        en = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", "tof_flag sticky while idle", 32'(tof_flag), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule